// File: doc/BRIEF.md
# Strobe-Gated Double-Data-Rate Read Capture

This block captures one byte lane of double-data-rate read data using the strobe that the memory device sends along with the data. After the controller issues a read, the block waits a programmed number of core cycles. It then opens a receive window on the strobe for a fixed span: one preamble period, then the data cycles, then one postamble period. Inside that window every strobe transition, whether rising or falling, stores the data lane into the next beat slot. When the strobe is outside the window, it has no effect.

The capture registers run on the strobe itself. A finished burst is written into one of two entries, and a toggle pointer hands it across to the core clock. On the core side the pointer is synchronised, the entry is read as one wide word, and a one-cycle valid pulse is raised. The check runs after the window closes and the crossing has had time to settle. If no complete burst has arrived by then, a sticky short-burst error is raised instead of a valid pulse.

Top module: `ddr_read_capture`

## Requirements
- R1: Within an open window, the k-th strobe transition (k counted from 0, even k on rising edges, odd k on falling edges) stores the data lane as beat k. Beat k appears in bits [8k+7:8k] of the output word.
- R2: A read command sampled at core edge E0 with latency L raises the gate output at edge E0+L+1. The gate then stays high for exactly PRE_CYC+BURST/2+POST_CYC core cycles (6 by default) and falls at the following edge.
- R3: Strobe transitions while the gate is low change neither the stored beats nor the edge count. They produce no valid pulse and leave the output word unchanged.
- R4: Every complete burst is delivered exactly once, as one valid pulse lasting a single core cycle. Consecutive bursts alternate between the two entries, and each one delivers its own data.
- R5: If the window closes and the settle period ends without a complete burst, the short-burst error goes high and no valid pulse is raised for that read. The error then stays high until reset.
- R6: Transitions beyond the BURST-th one inside the same window are ignored. The delivered word holds only the first BURST beats.
- R7: A read command that arrives after an accepted command and before that read's settle period ends is ignored. It does not reopen or extend the gate.
- R8: After reset, the gate, valid, error and data outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset (also clears the strobe-side pointer) |
| rd_cmd_i | input | 1 | Read command issued by the controller, one cycle |
| cfg_rd_lat_i | input | LAT_W | Read latency in core cycles, sampled with the command |
| dqs_i | input | 1 | Incoming data strobe |
| dq_i | input | LANE_W | Incoming data lane |
| gate_en_o | output | 1 | Strobe receiver enable (the gating window) |
| burst_o | output | BURST*LANE_W | Assembled burst, beat 0 in the low byte |
| burst_valid_o | output | 1 | One-cycle pulse when burst_o holds a new burst |
| short_err_o | output | 1 | Sticky short-burst error |

## Verification
Every read latency from 0 to 15 is swept with full eight-edge bursts, each carrying a data pattern derived from the latency. This shows that the gate opens and closes on the right edge for each latency, and that the beats are stored in the right order and in the right entry. Strobe toggling outside the window, and a second command during a window, show that the window is the only path into the capture registers. A ten-edge burst separates correct capping from overrun. Six-edge and zero-edge bursts, each followed by a good read, show that the error is raised, that it is sticky, and that a failed read leaves the next read unharmed.

// File: rtl/ddr_rdcap_pkg.sv
package ddr_rdcap_pkg;
  typedef enum logic [1:0] {
    GT_IDLE   = 2'd0,
    GT_WAIT   = 2'd1,
    GT_OPEN   = 2'd2,
    GT_SETTLE = 2'd3
  } gate_state_e;
endpackage

// File: rtl/ddr_rdcap_gate_timer.sv
module ddr_rdcap_gate_timer
  import ddr_rdcap_pkg::*;
#(
  parameter int LAT_W      = 4,
  parameter int GATE_CYC   = 6,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_cmd_i,
  input  logic [LAT_W-1:0] rd_lat_i,
  output logic             gate_o,
  output logic             check_o
);
  localparam int SPAN   = (GATE_CYC > SETTLE_CYC) ? GATE_CYC : SETTLE_CYC;
  localparam int SPAN_W = $clog2(SPAN + 1);
  localparam int TW     = (LAT_W > SPAN_W) ? LAT_W : SPAN_W;

  gate_state_e    st;
  logic [TW-1:0]  cnt;

  // Latency wait, then the open window, then a settle period for the crossing
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= GT_IDLE;
      cnt     <= '0;
      gate_o  <= 1'b0;
      check_o <= 1'b0;
    end else begin
      check_o <= 1'b0;
      unique case (st)
        GT_IDLE: begin
          if (rd_cmd_i) begin
            st  <= GT_WAIT;
            cnt <= TW'(rd_lat_i);
          end
        end
        GT_WAIT: begin
          if (cnt == '0) begin
            st     <= GT_OPEN;
            gate_o <= 1'b1;
            cnt    <= TW'(GATE_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        GT_OPEN: begin
          if (cnt == '0) begin
            st     <= GT_SETTLE;
            gate_o <= 1'b0;
            cnt    <= TW'(SETTLE_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        GT_SETTLE: begin
          if (cnt == '0) begin
            st      <= GT_IDLE;
            check_o <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= GT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddr_rdcap_strobe_capture.sv
module ddr_rdcap_strobe_capture #(
  parameter int LANE_W = 8,
  parameter int BURST  = 8
) (
  input  logic                    rst,
  input  logic                    gate_i,
  input  logic                    dqs_i,
  input  logic [LANE_W-1:0]       dq_i,
  output logic                    wr_ptr_o,
  output logic [BURST*LANE_W-1:0] ent0_o,
  output logic [BURST*LANE_W-1:0] ent1_o
);
  localparam int HALF  = BURST / 2;
  localparam int IDX_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int CNT_W = $clog2(HALF + 1);

  logic             clr;
  logic [CNT_W-1:0] rise_cnt;
  logic [CNT_W-1:0] fall_cnt;
  logic             rise_ok;
  logic             fall_ok;
  logic             fall_last;

  // Beats stored on rising edges (even) and falling edges (odd), per entry
  logic [LANE_W-1:0] even_q [2][HALF];
  logic [LANE_W-1:0] odd_q  [2][HALF];

  // Counters are held at zero whenever the window is closed
  assign clr       = rst | ~gate_i;
  assign rise_ok   = rise_cnt < CNT_W'(HALF);
  assign fall_ok   = fall_cnt < CNT_W'(HALF);
  assign fall_last = fall_ok && (fall_cnt == CNT_W'(HALF - 1));

  always_ff @(posedge dqs_i or posedge clr) begin
    if (clr)          rise_cnt <= '0;
    else if (rise_ok) rise_cnt <= rise_cnt + 1'b1;
  end

  always_ff @(negedge dqs_i or posedge clr) begin
    if (clr)          fall_cnt <= '0;
    else if (fall_ok) fall_cnt <= fall_cnt + 1'b1;
  end

  always_ff @(posedge dqs_i) begin
    if (gate_i && rise_ok)
      even_q[wr_ptr_o][rise_cnt[IDX_W-1:0]] <= dq_i;
  end

  always_ff @(negedge dqs_i) begin
    if (gate_i && fall_ok)
      odd_q[wr_ptr_o][fall_cnt[IDX_W-1:0]] <= dq_i;
  end

  // The last beat of a burst flips the entry pointer that the core side watches
  always_ff @(negedge dqs_i or posedge rst) begin
    if (rst)                      wr_ptr_o <= 1'b0;
    else if (gate_i && fall_last) wr_ptr_o <= ~wr_ptr_o;
  end

  for (genvar b = 0; b < BURST; b++) begin : g_pack
    if (b % 2 == 0) begin : g_even
      assign ent0_o[b*LANE_W +: LANE_W] = even_q[0][b/2];
      assign ent1_o[b*LANE_W +: LANE_W] = even_q[1][b/2];
    end else begin : g_odd
      assign ent0_o[b*LANE_W +: LANE_W] = odd_q[0][b/2];
      assign ent1_o[b*LANE_W +: LANE_W] = odd_q[1][b/2];
    end
  end
endmodule

// File: rtl/ddr_rdcap_handoff.sv
module ddr_rdcap_handoff #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ptr_i,
  input  logic [WORD_W-1:0] ent0_i,
  input  logic [WORD_W-1:0] ent1_i,
  input  logic              check_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              err_o
);
  logic [1:0] ptr_sync;
  logic       rd_ptr;
  logic       seen;
  logic       pend;

  assign pend = ptr_sync[1] ^ rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_sync <= '0;
      rd_ptr   <= 1'b0;
      seen     <= 1'b0;
      word_o   <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      ptr_sync <= {ptr_sync[0], wr_ptr_i};
      valid_o  <= pend;
      if (pend) begin
        word_o <= rd_ptr ? ent1_i : ent0_i;
        rd_ptr <= ~rd_ptr;
      end
      if (check_i) begin
        seen <= 1'b0;
        if (!seen && !pend) err_o <= 1'b1;
      end else if (pend) begin
        seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ddr_read_capture.sv
module ddr_read_capture #(
  parameter int LANE_W     = 8,
  parameter int BURST      = 8,
  parameter int PRE_CYC    = 1,
  parameter int POST_CYC   = 1,
  parameter int LAT_W      = 4,
  parameter int SETTLE_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_cmd_i,
  input  logic [LAT_W-1:0]        cfg_rd_lat_i,
  input  logic                    dqs_i,
  input  logic [LANE_W-1:0]       dq_i,
  output logic                    gate_en_o,
  output logic [BURST*LANE_W-1:0] burst_o,
  output logic                    burst_valid_o,
  output logic                    short_err_o
);
  localparam int GATE_CYC = PRE_CYC + BURST / 2 + POST_CYC;
  localparam int WORD_W   = BURST * LANE_W;

  logic              check;
  logic              wr_ptr;
  logic [WORD_W-1:0] ent0;
  logic [WORD_W-1:0] ent1;

  ddr_rdcap_gate_timer #(
    .LAT_W(LAT_W), .GATE_CYC(GATE_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) timer_i (
    .clk(clk), .rst(rst), .rd_cmd_i(rd_cmd_i), .rd_lat_i(cfg_rd_lat_i),
    .gate_o(gate_en_o), .check_o(check)
  );

  ddr_rdcap_strobe_capture #(
    .LANE_W(LANE_W), .BURST(BURST)
  ) cap_i (
    .rst(rst), .gate_i(gate_en_o), .dqs_i(dqs_i), .dq_i(dq_i),
    .wr_ptr_o(wr_ptr), .ent0_o(ent0), .ent1_o(ent1)
  );

  ddr_rdcap_handoff #(
    .WORD_W(WORD_W)
  ) hand_i (
    .clk(clk), .rst(rst), .wr_ptr_i(wr_ptr), .ent0_i(ent0), .ent1_i(ent1),
    .check_i(check), .word_o(burst_o), .valid_o(burst_valid_o),
    .err_o(short_err_o)
  );
endmodule

// File: rtl/ddr_read_capture_chk.sv
module ddr_read_capture_chk #(
  parameter int GATE_CYC = 6
) (
  input logic clk,
  input logic rst,
  input logic gate_en_o,
  input logic burst_valid_o,
  input logic short_err_o
);
  localparam int RW = $clog2(GATE_CYC + 2) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)            run <= '0;
    else if (gate_en_o) run <= run + 1'b1;
    else                run <= '0;
  end

  // R2: the window never outlasts its span
  a_r2_gate_short: assert property (@(posedge clk) disable iff (rst)
    gate_en_o |-> (run < RW'(GATE_CYC)));

  // R2: the window lasts its full span once it has opened
  a_r2_gate_full: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_en_o) |-> (run == RW'(GATE_CYC)));

  // R4: valid is a single-cycle pulse
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    burst_valid_o |=> !burst_valid_o);

  // R5: the error never clears without reset
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    short_err_o |=> short_err_o);

  // R5: a short burst raises no valid along with the error
  a_r5_err_no_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(short_err_o) |-> !burst_valid_o);
endmodule

bind ddr_read_capture ddr_read_capture_chk #(
  .GATE_CYC(PRE_CYC + BURST / 2 + POST_CYC)
) chk_i (
  .clk(clk), .rst(rst), .gate_en_o(gate_en_o),
  .burst_valid_o(burst_valid_o), .short_err_o(short_err_o)
);

// File: tb/ddr_read_capture_tb.sv
module ddr_read_capture_tb_top;
  localparam int LANE_W = 8;
  localparam int BURST  = 8;
  localparam int LAT_W  = 4;
  localparam int WORD_W = LANE_W * BURST;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rd_cmd = 1'b0;
  logic [LAT_W-1:0]  cfg_lat = '0;
  logic              dqs = 1'b0;
  logic [LANE_W-1:0] dq = '0;
  logic              gate_en;
  logic [WORD_W-1:0] word;
  logic              valid;
  logic              err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [WORD_W-1:0] last_word = '0;

  always #4 clk = ~clk;

  ddr_read_capture dut_i (
    .clk(clk), .rst(rst), .rd_cmd_i(rd_cmd), .cfg_rd_lat_i(cfg_lat),
    .dqs_i(dqs), .dq_i(dq), .gate_en_o(gate_en), .burst_o(word),
    .burst_valid_o(valid), .short_err_o(err)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] make_pat(input int seed);
    logic [WORD_W-1:0] p;
    for (int i = 0; i < BURST; i++)
      p[i*LANE_W +: LANE_W] = LANE_W'((seed * 53 + i * 29 + 11) ^ (i << 4));
    return p;
  endfunction

  // R3: strobe activity with the window closed
  task automatic stray(input int pairs);
    for (int i = 0; i < pairs; i++) begin
      @(negedge clk);
      dq = LANE_W'(8'hA5 ^ i);
      #1 dqs = 1'b1;
      #1 dq = LANE_W'(8'h3C + i);
      #1 dqs = 1'b0;
      chk(gate_en == 1'b0 && valid == 1'b0, "R3 stray edge no valid",
          {62'd0, gate_en, valid}, '0);
    end
    repeat (4) @(negedge clk);
    chk(word == last_word, "R3 word unchanged by stray edges", word, last_word);
  endtask

  task automatic do_read(input int lat, input int n_edges, input int seed,
                         input bit poke, input bit want_valid);
    logic [WORD_W-1:0] pat;
    logic [WORD_W-1:0] got;
    int vcnt;
    int e;
    pat  = make_pat(seed);
    got  = '0;
    vcnt = 0;
    e    = 0;
    @(negedge clk);
    rd_cmd  = 1'b1;
    cfg_lat = LAT_W'(lat);
    @(posedge clk);            // E0
    #1 rd_cmd = 1'b0;
    for (int k = 0; k < lat; k++) @(posedge clk);
    #1 chk(gate_en == 1'b0, "R2 gate low before open edge", {63'd0, gate_en}, '0);
    @(posedge clk);            // open edge E0+L+1
    #1 chk(gate_en == 1'b1, "R2 gate high at open edge", {63'd0, gate_en}, 1);
    if (poke) rd_cmd = 1'b1;   // R7 command during window
    @(posedge clk);            // preamble over
    #1 rd_cmd = 1'b0;
    for (int c = 0; c < 5; c++) begin
      if (c == 4)
        chk(gate_en == 1'b1, "R2 gate high in last cycle", {63'd0, gate_en}, 1);
      dq = (e < BURST) ? pat[e*LANE_W +: LANE_W] : LANE_W'(8'hEE);
      #1 if (e < n_edges) begin dqs = 1'b1; e++; end
      #2 dq = (e < BURST) ? pat[e*LANE_W +: LANE_W] : LANE_W'(8'h77);
      #2 if (e < n_edges) begin dqs = 1'b0; e++; end
      @(posedge clk);
      #1;
    end
    chk(gate_en == 1'b0, "R2 gate low after span", {63'd0, gate_en}, '0);
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      if (valid) begin vcnt++; got = word; end
      chk(gate_en == 1'b0, "R7 gate not reopened", {63'd0, gate_en}, '0);
    end
    if (want_valid) begin
      chk(vcnt == 1, "R4 one single-cycle valid", WORD_W'(vcnt), 1);
      chk(got == pat, (n_edges > BURST) ? "R6 extra edges ignored" : "R1 beat order",
          got, pat);
      last_word = pat;
    end else begin
      chk(vcnt == 0, "R5 no valid on short burst", WORD_W'(vcnt), '0);
      chk(word == last_word, "R5 word kept on short burst", word, last_word);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(gate_en == 0 && valid == 0 && err == 0, "R8 reset outputs",
        {61'd0, gate_en, valid, err}, '0);
    chk(word == '0, "R8 reset word", word, '0);

    stray(6);

    // R1 R2 R4 sweep of latencies, commands poked mid-window on odd ones (R7)
    for (int l = 0; l < 16; l++) begin
      do_read(l, BURST, l, (l % 2) == 1, 1'b1);
      chk(err == 1'b0, "R5 no error on full burst", {63'd0, err}, '0);
    end
    do_read(5, BURST, 100, 1'b0, 1'b1);
    do_read(5, BURST, 200, 1'b0, 1'b1);

    // R6 ten edges in the window
    do_read(2, 10, 300, 1'b0, 1'b1);

    stray(4);
    do_read(0, BURST, 400, 1'b0, 1'b1);

    // R5 short burst, then recovery with sticky flag
    do_read(3, 6, 500, 1'b0, 1'b0);
    chk(err == 1'b1, "R5 error set on short burst", {63'd0, err}, 1);
    do_read(1, BURST, 600, 1'b0, 1'b1);
    chk(err == 1'b1, "R5 error sticky", {63'd0, err}, 1);
    do_read(4, 0, 700, 1'b0, 1'b0);
    chk(err == 1'b1, "R5 error sticky after empty window", {63'd0, err}, 1);
    stray(3);
    do_read(7, BURST, 800, 1'b1, 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule